// File: doc/BRIEF.md
# Packed-Video Multiply-Add Unit

This block runs one packed-video multiply-add operation each cycle. From a 64-bit operation word it decodes how to take a narrow operand from each of two 32-bit source values. The operand is either one byte lane or one 16-bit half, and each operand is read as signed or unsigned. The second operand can instead come from a 16-bit immediate carried in the operation word. The two operands are multiplied and a 32-bit addend is added at full precision. The sum can then be shifted right arithmetically by 7 or 15 and clamped to the signed or unsigned 32-bit range before it is written out.

The unit sits behind an operand-read stage. The issuing logic presents the operation word and three source values with a valid strobe. One clock later the unit returns the registered result, an error flag for reserved operand encodings, and zero and sign flags for a condition-code write.

Top module: `pvmad_unit`

## Requirements
- R1: While reset is active all outputs are zero. `res_valid` is high in exactly the cycle after a cycle with `in_valid` high. `res_data`, `res_err`, `cc_zero` and `cc_sign` keep their values after an idle cycle.
- R2: When an operand's chunk flag is clear (bit 38 for A, bit 30 for B), its 2-bit select field (bits 37:36 for A, bits 29:28 for B) picks byte lane n. That lane is (src >> 8n) & 0xFF.
- R3: When the chunk flag is set, select code 0 takes the low 16 bits of the source and code 1 takes the upper 16 bits.
- R4: Bit 48 marks operand A as signed and bit 49 marks operand B as signed. A signed operand is sign-extended from its extracted width (8 or 16 bits), and an unsigned one is zero-extended.
- R5: When bit 50 is clear, operand B is the immediate in bits 35:20. It is sign-extended when bit 49 is set and zero-extended otherwise, and B's chunk and select fields are ignored.
- R6: The result is signed when bit 48 or bit 49 is set. In that case the addend C is sign-extended, otherwise it is zero-extended. A*B+C is formed without wrap before shift and saturation.
- R7: The shift field in bits 52:51 selects the operation on the sum: 0 means no shift, 1 means an arithmetic right shift by 7, 2 means an arithmetic right shift by 15, and 3 means no shift.
- R8: When bit 55 is set, the shifted sum is clamped to [-2^31, 2^31-1] if the result is signed, or to [0, 2^32-1] if it is unsigned. When bit 55 is clear, the low 32 bits are kept.
- R9: A chunk-mode select code of 2 or 3 makes that operand zero and sets `res_err` with the result. For B this applies only when bit 50 is set.
- R10: When bit 47 is set, `cc_we` is high together with `res_valid`, with `cc_zero` = (result == 0) and `cc_sign` = result bit 31. When bit 47 is clear, `cc_we` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation and sources presented this cycle |
| instr | input | 64 | Operation word |
| src_a | input | 32 | Source value for operand A |
| src_b | input | 32 | Source value for operand B |
| src_c | input | 32 | Addend |
| res_valid | output | 1 | Result available |
| res_data | output | 32 | Result |
| res_err | output | 1 | Reserved operand encoding seen |
| cc_we | output | 1 | Condition-code write strobe |
| cc_zero | output | 1 | Result is zero |
| cc_sign | output | 1 | Result bit 31 |

## Verification
Every result, error flag and condition-code flag is due in the cycle after the operation is presented, because there is a single register stage. The bench drives inputs at a falling edge and samples all outputs at the next falling edge, after exactly one rising edge. Between operations it leaves one idle cycle, so it can also check that the valid and condition-code strobes drop and that the data outputs hold. Expected values come from a bench function that models the operation with 64-bit integers.

// File: rtl/pvmad_pkg.sv
package pvmad_pkg;

   localparam int OPW_INSTR = 64;

   // field positions inside the operation word
   localparam int F_SGN_A = 48;
   localparam int F_SGN_B = 49;
   localparam int F_BREG  = 50;
   localparam int F_CHK_A = 38;
   localparam int F_SEL_A = 36;
   localparam int F_CHK_B = 30;
   localparam int F_SEL_B = 28;
   localparam int F_SHF   = 51;
   localparam int F_SAT   = 55;
   localparam int F_CCEN  = 47;
   localparam int F_IMM   = 20;

   typedef enum logic [1:0] {
      SHF_NONE = 2'd0,
      SHF_LO   = 2'd1,
      SHF_HI   = 2'd2,
      SHF_RSV  = 2'd3
   } shf_e;

   typedef enum logic [1:0] {
      HSEL_LO   = 2'd0,
      HSEL_HI   = 2'd1,
      HSEL_WORD = 2'd2,
      HSEL_BAD  = 2'd3
   } hsel_e;

   typedef struct packed {
      logic       sgn_a;
      logic       sgn_b;
      logic       b_reg;
      logic       chk_a;
      logic       chk_b;
      logic       sat;
      logic       cc_en;
      logic [1:0] sel_a;
      logic [1:0] sel_b;
      shf_e       shf;
   } ctl_t;

   function automatic ctl_t decode(input logic [OPW_INSTR-1:0] w);
      ctl_t c;
      c.sgn_a = w[F_SGN_A];
      c.sgn_b = w[F_SGN_B];
      c.b_reg = w[F_BREG];
      c.chk_a = w[F_CHK_A];
      c.chk_b = w[F_CHK_B];
      c.sat   = w[F_SAT];
      c.cc_en = w[F_CCEN];
      c.sel_a = w[F_SEL_A +: 2];
      c.sel_b = w[F_SEL_B +: 2];
      c.shf   = shf_e'(w[F_SHF +: 2]);
      return c;
   endfunction

endpackage

// File: rtl/pvmad_opsel.sv
module pvmad_opsel
   import pvmad_pkg::*;
#(
   parameter int DW  = 32,
   parameter int LW  = 8,
   parameter int OPW = DW/2 + 1
) (
   input  logic [DW-1:0]          val,
   input  logic                   chunk,
   input  logic [1:0]             sel,
   input  logic                   sgn,
   output logic signed [OPW-1:0]  opnd,
   output logic                   bad
);

   localparam int NL = DW / LW;
   localparam int HW = DW / 2;

   logic [LW-1:0] lane [NL];
   logic [LW-1:0] byte_v;
   logic [HW-1:0] half_v;
   logic          half_bad;

   generate
      for (genvar g = 0; g < NL; g++) begin : g_lane
         assign lane[g] = val[g*LW +: LW];
      end
   endgenerate

   assign byte_v = lane[sel];

   always_comb begin
      half_bad = 1'b0;
      half_v   = '0;
      case (hsel_e'(sel))
         HSEL_LO: half_v = val[HW-1:0];
         HSEL_HI: half_v = val[DW-1:HW];
         default: half_bad = 1'b1;
      endcase
   end

   always_comb begin
      if (!chunk) begin
         if (sgn) opnd = {{(OPW-LW){byte_v[LW-1]}}, byte_v};
         else     opnd = {{(OPW-LW){1'b0}}, byte_v};
      end else if (half_bad) begin
         opnd = '0;
      end else begin
         if (sgn) opnd = {{(OPW-HW){half_v[HW-1]}}, half_v};
         else     opnd = {{(OPW-HW){1'b0}}, half_v};
      end
   end

   assign bad = chunk & half_bad;

endmodule

// File: rtl/pvmad_bsrc.sv
module pvmad_bsrc #(
   parameter int DW    = 32,
   parameter int LW    = 8,
   parameter int IMM_W = 16,
   parameter int OPW   = DW/2 + 1
) (
   input  logic [DW-1:0]          val,
   input  logic                   chunk,
   input  logic [1:0]             sel,
   input  logic                   sgn,
   input  logic                   from_reg,
   input  logic [IMM_W-1:0]       imm,
   output logic signed [OPW-1:0]  opnd,
   output logic                   bad
);

   logic signed [OPW-1:0] reg_op;
   logic signed [OPW-1:0] imm_op;
   logic                  reg_bad;

   pvmad_opsel #(.DW(DW), .LW(LW), .OPW(OPW)) u_sel (
      .val   (val),
      .chunk (chunk),
      .sel   (sel),
      .sgn   (sgn),
      .opnd  (reg_op),
      .bad   (reg_bad)
   );

   generate
      if (IMM_W < OPW) begin : g_imm_ext
         assign imm_op = sgn ? {{(OPW-IMM_W){imm[IMM_W-1]}}, imm}
                             : {{(OPW-IMM_W){1'b0}}, imm};
      end else begin : g_imm_full
         assign imm_op = imm;
      end
   endgenerate

   assign opnd = from_reg ? reg_op : imm_op;
   assign bad  = from_reg & reg_bad;

endmodule

// File: rtl/pvmad_core.sv
module pvmad_core
   import pvmad_pkg::*;
#(
   parameter int DW     = 32,
   parameter int OPW    = DW/2 + 1,
   parameter int SH1    = 7,
   parameter int SH2    = 15,
   parameter bit SAT_EN = 1'b1
) (
   input  logic signed [OPW-1:0] opa,
   input  logic signed [OPW-1:0] opb,
   input  logic [DW-1:0]         addend,
   input  logic                  rsgn,
   input  shf_e                  shf,
   input  logic                  sat,
   output logic [DW-1:0]         res
);

   // product needs 2*OPW bits, the sum one more, plus a guard bit
   localparam int AW = 2*OPW + 2;

   localparam logic signed [AW-1:0] SMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [AW-1:0] SMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};
   localparam logic signed [AW-1:0] UMAX = {{(AW-DW){1'b0}}, {DW{1'b1}}};

   logic signed [AW-1:0] a_x, b_x, c_x;
   logic signed [AW-1:0] prod, sum, shifted;

   assign a_x  = {{(AW-OPW){opa[OPW-1]}}, opa};
   assign b_x  = {{(AW-OPW){opb[OPW-1]}}, opb};
   assign c_x  = rsgn ? {{(AW-DW){addend[DW-1]}}, addend}
                      : {{(AW-DW){1'b0}}, addend};
   assign prod = a_x * b_x;
   assign sum  = prod + c_x;

   always_comb begin
      case (shf)
         SHF_LO:  shifted = sum >>> SH1;
         SHF_HI:  shifted = sum >>> SH2;
         default: shifted = sum;
      endcase
   end

   generate
      if (SAT_EN) begin : g_sat
         always_comb begin
            res = shifted[DW-1:0];
            if (sat) begin
               if (rsgn) begin
                  if (shifted > SMAX)      res = SMAX[DW-1:0];
                  else if (shifted < SMIN) res = SMIN[DW-1:0];
               end else begin
                  if (shifted < 0)         res = '0;
                  else if (shifted > UMAX) res = UMAX[DW-1:0];
               end
            end
         end
      end else begin : g_wrap
         assign res = shifted[DW-1:0];
      end
   endgenerate

endmodule

// File: rtl/pvmad_unit.sv
module pvmad_unit
   import pvmad_pkg::*;
#(
   parameter int DW     = 32,
   parameter int LW     = 8,
   parameter int IMM_W  = 16,
   parameter int SH1    = 7,
   parameter int SH2    = 15,
   parameter bit SAT_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [OPW_INSTR-1:0] instr,
   input  logic [DW-1:0]        src_a,
   input  logic [DW-1:0]        src_b,
   input  logic [DW-1:0]        src_c,
   output logic                 res_valid,
   output logic [DW-1:0]        res_data,
   output logic                 res_err,
   output logic                 cc_we,
   output logic                 cc_zero,
   output logic                 cc_sign
);

   localparam int OPW = DW/2 + 1;

   generate
      if (DW / LW != 4 || DW % LW != 0) begin : g_chk_lanes
         $error("pvmad_unit: two-bit lane select needs exactly four lanes");
      end
      if (DW % 2 != 0) begin : g_chk_half
         $error("pvmad_unit: data width must be even");
      end
      if (IMM_W > DW/2 || F_IMM + IMM_W > OPW_INSTR) begin : g_chk_imm
         $error("pvmad_unit: immediate does not fit");
      end
      if (SH1 <= 0 || SH2 <= SH1 || SH2 >= DW) begin : g_chk_shift
         $error("pvmad_unit: shift amounts out of range");
      end
   endgenerate

   ctl_t                  ctl;
   logic signed [OPW-1:0] op_a, op_b;
   logic                  bad_a, bad_b;
   logic                  rsgn;
   logic [DW-1:0]         core_res;

   assign ctl  = decode(instr);
   assign rsgn = ctl.sgn_a | ctl.sgn_b;

   pvmad_opsel #(.DW(DW), .LW(LW), .OPW(OPW)) u_opa (
      .val   (src_a),
      .chunk (ctl.chk_a),
      .sel   (ctl.sel_a),
      .sgn   (ctl.sgn_a),
      .opnd  (op_a),
      .bad   (bad_a)
   );

   pvmad_bsrc #(.DW(DW), .LW(LW), .IMM_W(IMM_W), .OPW(OPW)) u_opb (
      .val      (src_b),
      .chunk    (ctl.chk_b),
      .sel      (ctl.sel_b),
      .sgn      (ctl.sgn_b),
      .from_reg (ctl.b_reg),
      .imm      (instr[F_IMM +: IMM_W]),
      .opnd     (op_b),
      .bad      (bad_b)
   );

   pvmad_core #(.DW(DW), .OPW(OPW), .SH1(SH1), .SH2(SH2), .SAT_EN(SAT_EN)) u_core (
      .opa    (op_a),
      .opb    (op_b),
      .addend (src_c),
      .rsgn   (rsgn),
      .shf    (ctl.shf),
      .sat    (ctl.sat),
      .res    (core_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
         res_err   <= 1'b0;
         cc_we     <= 1'b0;
         cc_zero   <= 1'b0;
         cc_sign   <= 1'b0;
      end else begin
         res_valid <= in_valid;
         cc_we     <= in_valid & ctl.cc_en;
         if (in_valid) begin
            res_data <= core_res;
            res_err  <= bad_a | bad_b;
            cc_zero  <= (core_res == '0);
            cc_sign  <= core_res[DW-1];
         end
      end
   end

endmodule

// File: rtl/pvmad_chk.sv
module pvmad_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [63:0]   instr,
   input logic [DW-1:0] src_c,
   input logic          res_valid,
   input logic [DW-1:0] res_data,
   input logic          res_err,
   input logic          cc_we,
   input logic          cc_zero
);

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);

   a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid);

   a_r1_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(res_data));

   a_r9_bad_a_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[38] && instr[37]) |=> res_err);

   a_r9_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[38] && instr[37] && instr[52:51] == 2'd0 && !instr[55])
      |=> (res_data == $past(src_c)));

   a_r10_cc_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[47]) |=> cc_we);

   a_r10_cc_gated: assert property (@(posedge clk) disable iff (!rst_n)
      cc_we |-> res_valid);

   a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cc_we |-> (cc_zero == (res_data == '0)));

endmodule

bind pvmad_unit pvmad_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .instr     (instr),
   .src_c     (src_c),
   .res_valid (res_valid),
   .res_data  (res_data),
   .res_err   (res_err),
   .cc_we     (cc_we),
   .cc_zero   (cc_zero)
);

// File: tb/sim_pvmad_unit.sv
module sim_pvmad_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] instr = '0;
   logic [31:0] src_a = '0, src_b = '0, src_c = '0;
   logic        res_valid, res_err, cc_we, cc_zero, cc_sign;
   logic [31:0] res_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pvmad_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .instr     (instr),
      .src_a     (src_a),
      .src_b     (src_b),
      .src_c     (src_c),
      .res_valid (res_valid),
      .res_data  (res_data),
      .res_err   (res_err),
      .cc_we     (cc_we),
      .cc_zero   (cc_zero),
      .cc_sign   (cc_sign)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input bit sa, sb, breg, ca, input bit [1:0] ta,
                                      input bit cb, input bit [1:0] tb, input bit [1:0] sh,
                                      input bit sat, cc, input bit [15:0] imm);
      logic [63:0] w = '0;
      w[48] = sa; w[49] = sb; w[50] = breg;
      w[38] = ca; w[37:36] = ta;
      w[35:20] = imm;
      w[30] = cb; w[29:28] = tb;
      w[52:51] = sh; w[55] = sat; w[47] = cc;
      return w;
   endfunction

   function automatic longint pick(input logic [31:0] v, input bit chunk,
                                   input bit [1:0] code, input bit sgn, output bit bad);
      longint x;
      bad = 1'b0;
      if (!chunk) begin
         x = longint'((v >> (code * 8)) & 32'hFF);
         if (sgn && x > 127) x = x - 256;
      end else if (code == 2'd0) begin
         x = longint'(v & 32'hFFFF);
         if (sgn && x > 32767) x = x - 65536;
      end else if (code == 2'd1) begin
         x = longint'(v >> 16);
         if (sgn && x > 32767) x = x - 65536;
      end else begin
         x = 0;
         bad = 1'b1;
      end
      return x;
   endfunction

   function automatic void model(input logic [63:0] w, input logic [31:0] a, b, c,
                                 output logic [31:0] r, output bit e);
      longint oa, ob, cx, s;
      bit ea, eb, rs;
      oa = pick(a, w[38], w[37:36], w[48], ea);
      if (w[50]) ob = pick(b, w[30], w[29:28], w[49], eb);
      else begin
         eb = 1'b0;
         ob = w[49] ? longint'($signed(w[35:20])) : longint'(w[35:20]);
      end
      rs = w[48] | w[49];
      cx = rs ? longint'($signed(c)) : longint'({32'b0, c});
      s  = oa * ob + cx;
      if (w[52:51] == 2'd1) s = s >>> 7;
      else if (w[52:51] == 2'd2) s = s >>> 15;
      if (w[55]) begin
         if (rs) begin
            if (s > 64'sd2147483647) s = 64'sd2147483647;
            else if (s < -64'sd2147483648) s = -64'sd2147483648;
         end else begin
            if (s < 0) s = 0;
            else if (s > 64'sd4294967295) s = 64'sd4294967295;
         end
      end
      r = s[31:0];
      e = ea | eb;
   endfunction

   task automatic run(input string tag, input logic [63:0] w, input logic [31:0] a, b, c);
      logic [31:0] er;
      bit ee;
      @(negedge clk);
      instr = w; src_a = a; src_b = b; src_c = c; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      model(w, a, b, c, er, ee);
      chk("R1", "res_valid", {31'b0, res_valid}, 32'd1);
      chk(tag, "res_data", res_data, er);
      chk(tag, "res_err", {31'b0, res_err}, {31'b0, ee});
      chk("R10", "cc_we", {31'b0, cc_we}, {31'b0, w[47]});
      if (w[47]) begin
         chk("R10", "cc_zero", {31'b0, cc_zero}, {31'b0, (er == 32'd0)});
         chk("R10", "cc_sign", {31'b0, cc_sign}, {31'b0, er[31]});
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog expired: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "reset res_valid", {31'b0, res_valid}, 32'd0);
      chk("R1", "reset res_data", res_data, 32'd0);
      chk("R1", "reset cc_we", {31'b0, cc_we}, 32'd0);
      chk("R1", "reset res_err", {31'b0, res_err}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 byte lanes, unsigned, register B
      for (int l = 0; l < 4; l++)
         run("R2", mk(0,0,1,0,2'(l),0,2'(3-l),0,0,1,16'h0), 32'h8844_22F1, 32'h0377_9A05, 32'd1000);
      // R3 halves
      run("R3", mk(0,0,1,1,0,1,1,0,0,1,16'h0), 32'hABCD_1234, 32'h00FF_7777, 32'd5);
      run("R3", mk(0,0,1,1,1,1,0,0,0,0,16'h0), 32'hFFFF_0002, 32'h1234_FFFF, 32'd0);
      // R4 signed operands
      run("R4", mk(1,0,1,0,2'd3,0,2'd0,0,0,1,16'h0), 32'h80FF_FFFF, 32'h0000_0003, 32'd0);
      run("R4", mk(1,1,1,1,0,1,1,0,0,1,16'h0), 32'h0000_8000, 32'hFFFF_0000, 32'd7);
      // R5 immediate B, signed and unsigned; B chunk bits ignored
      run("R5", mk(0,1,0,0,0,1,2'd3,0,0,1,16'h8001), 32'h0000_0002, 32'hDEAD_BEEF, 32'd0);
      run("R5", mk(0,0,0,0,0,1,2'd3,0,0,0,16'h8001), 32'h0000_0002, 32'hDEAD_BEEF, 32'd1);
      // R6 addend signedness and full-precision sum
      run("R6", mk(1,0,1,0,0,0,0,0,0,1,16'h0), 32'h0000_0002, 32'h0000_0003, 32'hFFFF_FFF0);
      run("R6", mk(0,0,1,0,0,0,0,0,0,1,16'h0), 32'h0000_0002, 32'h0000_0003, 32'hFFFF_FFF0);
      run("R6", mk(0,0,1,1,1,1,1,2'd2,0,0,16'h0), 32'hFFFF_0000, 32'hFFFF_0000, 32'hFFFF_FFFF);
      // R7 shifts on negative and positive sums
      run("R7", mk(1,0,1,1,0,1,0,2'd1,0,1,16'h0), 32'h0000_8000, 32'h0000_0100, 32'd0);
      run("R7", mk(1,0,1,1,0,1,0,2'd2,0,1,16'h0), 32'h0000_8000, 32'h0000_FFFF, 32'd3);
      run("R7", mk(0,0,1,1,0,1,0,2'd3,0,0,16'h0), 32'h0000_1234, 32'h0000_0010, 32'd9);
      // R8 saturation
      run("R8", mk(1,0,1,1,0,0,0,0,1,1,16'h0), 32'h0000_7FFF, 32'h0000_00FF, 32'h7FFF_FFFF);
      run("R8", mk(1,0,1,1,0,0,0,0,1,1,16'h0), 32'h0000_8000, 32'h0000_00FF, 32'h8000_0000);
      run("R8", mk(0,0,1,1,0,1,0,0,1,1,16'h0), 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF);
      run("R8", mk(0,0,1,1,0,1,0,0,0,1,16'h0), 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF);
      // R9 reserved codes
      run("R9", mk(0,0,1,1,2'd2,0,0,0,0,1,16'h0), 32'hFFFF_FFFF, 32'h0000_0005, 32'd0);
      run("R9", mk(1,1,1,0,1,1,2'd3,0,0,1,16'h0), 32'h0000_7700, 32'hFFFF_FFFF, 32'd11);
      run("R9", mk(0,0,0,0,1,1,2'd3,0,0,1,16'h0004), 32'h0000_0300, 32'hFFFF_FFFF, 32'd11);
      // R10 condition codes on zero result, then disabled
      run("R10", mk(0,0,1,0,0,0,0,0,0,1,16'h0), 32'h0, 32'h0, 32'h0);
      run("R10", mk(0,0,1,0,0,0,0,0,0,0,16'h0), 32'h5, 32'h5, 32'h0);

      // R1 idle cycle: strobes drop, data holds
      held = res_data;
      @(negedge clk);
      chk("R1", "idle res_valid", {31'b0, res_valid}, 32'd0);
      chk("R1", "idle cc_we", {31'b0, cc_we}, 32'd0);
      chk("R1", "idle res_data hold", res_data, held);

      // random mix
      for (int i = 0; i < 400; i++)
         run("R6", {$urandom, $urandom}, $urandom, $urandom, $urandom);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule